// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Force

The controller collects fifteen interrupt request lines, numbered 1 to 15, and turns each rising edge into a sticky pending bit. Every register bit n belongs to source n, and bit 0 is always unused. A per-source mask blocks a request when its bit is 1. The highest-numbered request that is pending or forced, and not masked, is presented to the processor as a registered 4-bit level. The level is 0 when no request qualifies.

Software reaches the block through a 32-bit register port that is addressed by word offset. It clears pending bits through a dedicated write-one-to-clear register. It raises test requests through a force register, which accepts writes only while an enable bit in a test-control register is set. The processor acknowledges a level on a separate input, and that acknowledge clears the matching pending bit.

A shape register is provided as plain read/write storage. It has no effect on how the inputs are detected.

Top module: `irq_hub`

## Requirements
- R1: After reset, the pending and force registers read 0, the mask register reads 0xFFFE (all source bits set), the test-control register reads 0, and `irq_level` is 0.
- R2: A rising edge on `src_in[n]` sets pending bit n on the next clock edge. A line that stays high does not set the bit again once it has been cleared.
- R3: The word offsets are 17 for shape, 18 for pending, 19 for mask, 20 for clear, 21 for force and 52 for test-control. `rdata` carries the addressed word in the cycle after `rd_en`. Bit 0 of every register reads 0, and any unmapped offset reads 0.
- R4: Writing to the clear register clears every pending bit whose write-data bit is 1, and leaves the other pending bits alone. Writes to the pending register are ignored.
- R5: When a rising edge and a clear hit the same bit in the same cycle, the pending bit ends up set.
- R6: A mask bit of 1 keeps its source out of `irq_level`. A mask bit of 0 lets the source through.
- R7: Bit 19 of the test-control register is the force enable. A write to the force register changes that register only while the enable is 1. The force register reads back what was written. A forced request persists until software writes its bit to 0, and the clear register does not remove it.
- R8: `irq_level` is the highest source number whose request is pending or forced and also unmasked, or 0 if there is none. It updates one clock edge after the request state changes.
- R9: `ack_valid` with `ack_level` = n clears pending bit n at that clock edge.
- R10: The shape register stores and reads back its source bits, and it has no effect on edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src_in | input | 15 | Request lines, bit n is source n |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest qualifying request level, registered |

## Verification
The bench builds the block at its default of fifteen sources. That size is small enough to cover every source alone, every ordered pair of sources for priority, and every mask threshold against a full set of pending requests. Expected levels are computed as the highest set bit of the bench's own request model. The force gating, clear-versus-edge collisions and acknowledge paths are exercised on individual sources within that same configuration.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_SHAPE = 6'd17;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 6'd18;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'd19;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'd20;
  localparam logic [ADDR_W-1:0] OFF_FORCE = 6'd21;
  localparam logic [ADDR_W-1:0] OFF_TEST  = 6'd52;
  localparam int TEN_BIT = 19;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int N = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [N:1] src,
  output logic [N:1] rise
);
  logic [N:1] prev_q;

  generate
    for (genvar g = 1; g <= N; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) prev_q[g] <= 1'b0;
        else     prev_q[g] <= src[g];
      end
      assign rise[g] = src[g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N  = 15,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [N:1]        rise,
  input  logic              ack_valid,
  input  logic [LW-1:0]     ack_level,
  output logic [N:1]        req
);
  logic [N:1] pend_q, mask_q, frc_q, shape_q;
  logic       ten_q;
  logic [N:1] clr_vec, ack_vec;
  logic       clr_hit, frc_hit;

  assign clr_hit = wr_en && (addr == OFF_CLR);
  assign frc_hit = wr_en && (addr == OFF_FORCE);
  assign clr_vec = clr_hit ? wdata[N:1] : '0;

  generate
    for (genvar g = 1; g <= N; g++) begin : g_ack
      assign ack_vec[g] = ack_valid && (ack_level == LW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= '1;
      frc_q   <= '0;
      shape_q <= '0;
      ten_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(clr_vec | ack_vec)) | rise;
      if (wr_en && addr == OFF_MASK)  mask_q  <= wdata[N:1];
      if (wr_en && addr == OFF_SHAPE) shape_q <= wdata[N:1];
      if (wr_en && addr == OFF_TEST)  ten_q   <= wdata[TEN_BIT];
      if (frc_hit && ten_q)           frc_q   <= wdata[N:1];
    end
  end

  assign req = (pend_q | frc_q) & ~mask_q;

  function automatic logic [DW-1:0] widen(input logic [N:1] v);
    logic [DW-1:0] w;
    w = '0;
    w[N:1] = v;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFF_SHAPE: rdata <= widen(shape_q);
        OFF_PEND:  rdata <= widen(pend_q);
        OFF_MASK:  rdata <= widen(mask_q);
        OFF_FORCE: rdata <= widen(frc_q);
        OFF_TEST:  rdata <= DW'(ten_q) << TEN_BIT;
        default:   rdata <= '0;
      endcase
    end
  end

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && rise == '0) |=> ((pend_q & $past(wdata[N:1])) == '0));
  p_force_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (frc_hit && !ten_q) |=> $stable(frc_q));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_vec != '0 && rise == '0) |=> ((pend_q & $past(ack_vec)) == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 15,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N:1]    req,
  output logic [LW-1:0] level
);
  logic [LW-1:0] lvl_n;

  always_comb begin
    lvl_n = '0;
    for (int i = 1; i <= N; i++)
      if (req[i]) lvl_n = LW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= lvl_n;
  end

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (level == '0));
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> (level != '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int N  = 15,
  parameter int DW = 32,
  parameter int LW = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [N:1]        src_in,
  input  logic              ack_valid,
  input  logic [LW-1:0]     ack_level,
  output logic [LW-1:0]     irq_level
);
  logic [N:1] rise, req;

  irq_edge #(.N(N)) u_edge (
    .clk(clk), .rst(rst), .src(src_in), .rise(rise)
  );

  irq_regs #(.N(N), .DW(DW), .LW(LW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rise(rise), .ack_valid(ack_valid),
    .ack_level(ack_level), .req(req)
  );

  irq_prio #(.N(N), .LW(LW)) u_prio (
    .clk(clk), .rst(rst), .req(req), .level(irq_level)
  );
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, ack_valid = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:1] src_in = '0;
  logic [3:0]  ack_level = '0, irq_level;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [5:0] A_SHAPE = 17, A_PEND = 18, A_MASK = 19,
                         A_CLR = 20, A_FORCE = 21, A_TEST = 52;

  always #10 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in), .ack_valid(ack_valid),
    .ack_level(ack_level), .irq_level(irq_level)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; tick(); rd_en = 0; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] top_bit(input logic [15:0] v);
    logic [3:0] r = 0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(); tick(); rst = 0; tick();
    // R1 reset state
    rd(A_PEND, d);  chk("R1 pending", d, 0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'hFFFE);
    rd(A_FORCE, d); chk("R1 force", d, 0);
    rd(A_TEST, d);  chk("R1 test", d, 0);
    chk("R1 level", 32'(irq_level), 0);
    // R6: masked source does not reach the level
    src_in[7] = 1; tick(); tick();
    chk("R6 masked level", 32'(irq_level), 0);
    rd(A_PEND, d); chk("R2 pending while masked", d, 32'h80);
    wr(A_MASK, 32'h0000FFFF); rd(A_MASK, d); chk("R3 mask bit0", d, 32'hFFFE);
    wr(A_MASK, 0); tick();
    chk("R6 unmasked level", 32'(irq_level), 7);
    src_in = '0; wr(A_CLR, 32'hFFFE); tick();
    // R2/R4/R8: every source alone
    for (int n = 1; n <= 15; n++) begin
      src_in[n] = 1; tick(); tick();
      chk("R8 single level", 32'(irq_level), 32'(n));
      rd(A_PEND, d); chk("R2 single pending", d, 32'(1) << n);
      wr(A_CLR, 32'(1) << n); tick();
      rd(A_PEND, d); chk("R4 cleared, R2 no retrigger", d, 0);
      chk("R8 level after clear", 32'(irq_level), 0);
      src_in[n] = 0; tick();
    end
    // R8: every pair
    for (int i = 1; i <= 15; i++)
      for (int j = i + 1; j <= 15; j++) begin
        src_in = '0; wr(A_CLR, 32'hFFFE);
        src_in[i] = 1; src_in[j] = 1; tick(); tick();
        chk("R8 pair priority", 32'(irq_level), 32'(j));
      end
    // R4: zero bits untouched, pending writes ignored
    src_in = '0; wr(A_CLR, 32'hFFFE);
    src_in = 15'h7FFF; tick(); src_in = '0;
    wr(A_CLR, 32'h0000AAAA);
    rd(A_PEND, d); chk("R4 partial clear", d, 32'h5554);
    wr(A_PEND, 0);
    rd(A_PEND, d); chk("R4 pending write ignored", d, 32'h5554);
    // R6: mask sweep against all pending
    src_in = 15'h7FFF; tick(); src_in = '0;
    for (int k = 15; k >= 1; k--) begin
      logic [31:0] m;
      m = (32'h10000 - (32'(1) << k)) & 32'hFFFE;
      wr(A_MASK, m); tick();
      chk("R6 mask threshold", 32'(irq_level), 32'(top_bit(16'hFFFE & ~m[15:0])));
    end
    wr(A_MASK, 0); wr(A_CLR, 32'hFFFE); tick();
    // R9 acknowledge
    src_in[9] = 1; src_in[4] = 1; tick(); tick();
    chk("R9 level before ack", 32'(irq_level), 9);
    ack_valid = 1; ack_level = 9; tick(); ack_valid = 0;
    rd(A_PEND, d); chk("R9 ack cleared", d, 32'h10);
    chk("R9 next level", 32'(irq_level), 4);
    src_in = '0; wr(A_CLR, 32'hFFFE); tick();
    // R5 set wins over clear
    src_in[6] = 1; tick(); src_in[6] = 0; tick();
    src_in[6] = 1; wr(A_CLR, 32'h40);
    rd(A_PEND, d); chk("R5 set wins", d, 32'h40);
    src_in = '0; wr(A_CLR, 32'hFFFE); tick();
    // R7 force
    wr(A_FORCE, 32'h20); tick();
    rd(A_FORCE, d); chk("R7 locked force", d, 0);
    chk("R7 locked level", 32'(irq_level), 0);
    wr(A_TEST, 32'h00080000); rd(A_TEST, d); chk("R7 enable readback", d, 32'h80000);
    wr(A_FORCE, 32'h20); tick();
    rd(A_FORCE, d); chk("R7 force readback", d, 32'h20);
    chk("R7 forced level", 32'(irq_level), 5);
    wr(A_CLR, 32'hFFFE); tick();
    chk("R7 clear keeps force", 32'(irq_level), 5);
    wr(A_MASK, 32'h20); tick();
    chk("R6 force masked", 32'(irq_level), 0);
    wr(A_MASK, 0); wr(A_TEST, 0); wr(A_FORCE, 0); tick();
    chk("R7 disabled write kept", 32'(irq_level), 5);
    wr(A_TEST, 32'h80000); wr(A_FORCE, 0); tick();
    chk("R7 force removed", 32'(irq_level), 0);
    // R10 shape, R3 unmapped
    wr(A_SHAPE, 32'hAAAA); rd(A_SHAPE, d); chk("R10 shape readback", d, 32'hAAAA);
    src_in[3] = 1; tick(); tick();
    chk("R10 edge unaffected", 32'(irq_level), 3);
    rd(6'd0, d); chk("R3 unmapped", d, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule